// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block watches one external interrupt pin and turns its activity into a sticky interrupt request. A 4-bit configuration register controls its behaviour. It sets whether the pin is listened to at all, and which polarity is the active one. It also picks between single-edge and dual-edge detection, and sets whether a detected edge also sends a one-cycle start pulse to a companion timer. The pin is brought into the clock domain through a synchroniser chain. Edges are found by comparing successive synchronised samples.

The CPU side writes and reads the configuration register. It also reads a level-match status that tells whether the synchronised pin currently sits at the active level, and it drops the request with a clear pulse. Rewriting the enable or polarity field can change the active level that the detector sees. That change is treated as an edge of its own and may raise the request, so software clears the flag after such a write. A separate 1-bit source select picks which of two internal interrupt sources drives a shared interrupt line. The timer source is chosen after reset.

Two small state machines carry the sequential behaviour. The request machine has the states `REQ_IDLE` and `REQ_PEND`. The transition *raise* goes from `REQ_IDLE` to `REQ_PEND` on any set condition. The transition *drop* goes from `REQ_PEND` to `REQ_IDLE` on a clear with no set in the same cycle. The timer-start machine has the states `TS_IDLE` and `TS_FIRE`. The transition *arm* enters `TS_FIRE` on a qualifying edge while timer start is enabled. The transition *disarm* returns to `TS_IDLE` in the next cycle that has no such edge. `TS_FIRE` may also repeat itself on back-to-back qualifying edges.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset the configuration reads 0000, the source select reads 0, and the request and the timer-start pulse are 0.
- R2: While configuration bit 3 (enable) is 0, no pin edge sets the request or produces a timer-start pulse.
- R3: With bit 3 = 1, bit 2 = 0 and bit 1 = 0, a falling pin edge sets the request and a rising edge does not. The request rises on the third rising clock edge after the pin changes (two synchroniser stages plus the flag).
- R4: With bit 3 = 1, bit 2 = 1 and bit 1 = 0, a rising pin edge sets the request and a falling edge does not.
- R5: With bit 3 = 1 and bit 1 = 1, both rising and falling pin edges set the request, whatever the value of bit 2.
- R6: The level-match status is 1 when the synchronised pin level equals bit 2 (0 = low active, 1 = high active). It follows a pin change two clock edges later.
- R7: A configuration write sets the request in the write cycle's clock edge exactly when the active condition (enable AND pin at the active level) under the new bits 3 and 2 differs from that under the old ones. A write that changes neither of these bits, or leaves the active condition unchanged, does not set it.
- R8: The request stays at 1 until a clear pulse arrives. If a set condition and a clear arrive in the same cycle, the request stays at 1.
- R9: When bit 0 = 1, each qualifying pin edge produces a one-cycle timer-start pulse in the same cycle in which the request rises. With bit 0 = 0, or for a configuration-write pseudo-edge, no pulse is produced.
- R10: With source select 0 the shared interrupt output follows the timer interrupt input. With 1 it follows the serial interrupt input.
- R11: The configuration register and the source select read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | External interrupt pin, asynchronous |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration write data (3 enable, 2 polarity, 1 both edges, 0 timer start) |
| cfg_rdata_o | output | 4 | Configuration read data |
| sel_wr_i | input | 1 | Source select write strobe |
| sel_wdata_i | input | 1 | Source select write data |
| sel_o | output | 1 | Current source select |
| req_clr_i | input | 1 | Request clear pulse |
| req_o | output | 1 | Interrupt request flag |
| lvl_match_o | output | 1 | Synchronised pin is at the active level |
| tmr_start_o | output | 1 | Timer count-start pulse |
| tmr_irq_i | input | 1 | Timer interrupt source |
| ser_irq_i | input | 1 | Serial interrupt source |
| shared_irq_o | output | 1 | Selected interrupt source |

## Verification
The request flag's set path and its clear pulse can fall in the same cycle. The bench provokes this by driving a configuration write that flips the active condition together with a clear while the flag is already up, and judges that the flag stays at 1. A clear on its own must then drop it. The timer-start pulse and the request rise also share one clock edge. They are sampled together in the cycle after the third clock edge that follows a pin change.

// File: rtl/xint_pkg.sv
`timescale 1ns/1ps
package xint_pkg;
    localparam int CFG_W     = 4;
    localparam int BIT_EN    = 3;
    localparam int BIT_POL   = 2;
    localparam int BIT_BOTH  = 1;
    localparam int BIT_TSYNC = 0;

    typedef struct packed {
        logic en;
        logic pol;
        logic both;
        logic tsync;
    } cfg_t;

    typedef enum logic {REQ_IDLE = 1'b0, REQ_PEND = 1'b1} req_state_t;
    typedef enum logic {TS_IDLE  = 1'b0, TS_FIRE  = 1'b1} ts_state_t;
endpackage

// File: rtl/xint_pin_sync.sv
`timescale 1ns/1ps
module xint_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Synchroniser chain, one flop per stage.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Previous synchronised sample for edge comparison.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain[LAST];
    end

    assign lvl_o  = chain[LAST];
    assign rise_o =  chain[LAST] & ~prev_q;
    assign fall_o = ~chain[LAST] &  prev_q;
endmodule

// File: rtl/xint_req_fsm.sv
`timescale 1ns/1ps
module xint_req_fsm
    import xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic req_o
);
    req_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= REQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REQ_IDLE: if (set_i)            state_d = REQ_PEND;  // raise
            REQ_PEND: if (clr_i && !set_i)  state_d = REQ_IDLE;  // drop; set wins
            default:                        state_d = REQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            REQ_PEND: req_o = 1'b1;
            default:  req_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xint_start_fsm.sv
`timescale 1ns/1ps
module xint_start_fsm
    import xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic pulse_o
);
    ts_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: if (fire_i) state_d = TS_FIRE;     // arm
            TS_FIRE: state_d = fire_i ? TS_FIRE : TS_IDLE; // disarm
            default: state_d = TS_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TS_FIRE: pulse_o = 1'b1;
            default: pulse_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ext_irq_detect.sv
`timescale 1ns/1ps
module ext_irq_detect
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  logic             sel_wr_i,
    input  logic             sel_wdata_i,
    output logic             sel_o,
    input  logic             req_clr_i,
    output logic             req_o,
    output logic             lvl_match_o,
    output logic             tmr_start_o,
    input  logic             tmr_irq_i,
    input  logic             ser_irq_i,
    output logic             shared_irq_o
);
    cfg_t cfg_q, cfg_new;
    logic sel_q;
    logic lvl, rise, fall;
    logic edge_hit, pseudo_hit, act_old, act_new;

    // Configuration and source-select registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            sel_q <= 1'b0;
        end else begin
            if (cfg_wr_i) cfg_q <= cfg_new;
            if (sel_wr_i) sel_q <= sel_wdata_i;
        end
    end

    assign cfg_new = cfg_t'(cfg_wdata_i);

    xint_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    // Qualifying edge under the current settings.
    always_comb begin
        if (!cfg_q.en)       edge_hit = 1'b0;
        else if (cfg_q.both) edge_hit = rise | fall;
        else                 edge_hit = cfg_q.pol ? rise : fall;
    end

    // Pseudo-edge: active condition changes across a write.
    assign act_old    = cfg_q.en   & (lvl == cfg_q.pol);
    assign act_new    = cfg_new.en & (lvl == cfg_new.pol);
    assign pseudo_hit = cfg_wr_i & (act_old != act_new);

    xint_req_fsm u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (edge_hit | pseudo_hit),
        .clr_i (req_clr_i),
        .req_o (req_o)
    );

    xint_start_fsm u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (edge_hit & cfg_q.tsync),
        .pulse_o (tmr_start_o)
    );

    assign cfg_rdata_o  = cfg_q;
    assign sel_o        = sel_q;
    assign lvl_match_o  = (lvl == cfg_q.pol);
    assign shared_irq_o = sel_q ? ser_irq_i : tmr_irq_i;
endmodule

// File: rtl/xint_checker.sv
`timescale 1ns/1ps
module xint_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cfg_rdata_o,
    input logic       cfg_wr_i,
    input logic       req_o,
    input logic       req_clr_i,
    input logic       tmr_start_o,
    input logic       sel_o,
    input logic       tmr_irq_i,
    input logic       ser_irq_i,
    input logic       shared_irq_o
);
    a_r8_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !req_clr_i) |=> req_o);

    a_r8_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_o) |-> $past(req_clr_i));

    a_r2_disabled_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rdata_o[3] && !cfg_wr_i) |=> !$rose(req_o));

    a_r9_pulse_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start_o |-> req_o);

    a_r9_pulse_needs_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_start_o |-> $past(cfg_rdata_o[0]));

    a_r10_serial_route: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> (shared_irq_o == ser_irq_i));

    a_r10_timer_route: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_o |-> (shared_irq_o == tmr_irq_i));
endmodule

bind ext_irq_detect xint_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rdata_o  (cfg_rdata_o),
    .cfg_wr_i     (cfg_wr_i),
    .req_o        (req_o),
    .req_clr_i    (req_clr_i),
    .tmr_start_o  (tmr_start_o),
    .sel_o        (sel_o),
    .tmr_irq_i    (tmr_irq_i),
    .ser_irq_i    (ser_irq_i),
    .shared_irq_o (shared_irq_o)
);

// File: tb/tb_ext_irq_detect.sv
`timescale 1ns/1ps
module tb_ext_irq_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b0;
    logic       cfg_wr_i = 1'b0;
    logic [3:0] cfg_wdata_i = 4'h0;
    logic [3:0] cfg_rdata_o;
    logic       sel_wr_i = 1'b0;
    logic       sel_wdata_i = 1'b0;
    logic       sel_o;
    logic       req_clr_i = 1'b0;
    logic       req_o, lvl_match_o, tmr_start_o, shared_irq_o;
    logic       tmr_irq_i = 1'b0;
    logic       ser_irq_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    ext_irq_detect dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i), .sel_o(sel_o),
        .req_clr_i(req_clr_i), .req_o(req_o), .lvl_match_o(lvl_match_o),
        .tmr_start_o(tmr_start_o), .tmr_irq_i(tmr_irq_i), .ser_irq_i(ser_irq_i),
        .shared_irq_o(shared_irq_o)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [3:0] v);
        cfg_wr_i = 1'b1; cfg_wdata_i = v;
        cyc(1);
        cfg_wr_i = 1'b0;
    endtask

    task automatic clear_req();
        req_clr_i = 1'b1;
        cyc(1);
        req_clr_i = 1'b0;
    endtask

    // Change the pin and sample after the flag edge (3 clock edges).
    task automatic move_pin(input logic v);
        pin_i = v;
        cyc(3);
    endtask

    task automatic t_reset();
        check("R1 cfg", cfg_rdata_o, 4'h0);
        check("R1 sel", {3'b0, sel_o}, 4'h0);
        check("R1 req", {3'b0, req_o}, 4'h0);
        check("R1 tstart", {3'b0, tmr_start_o}, 4'h0);
    endtask

    task automatic t_disabled();
        write_cfg(4'b0011);
        move_pin(1'b1);
        check("R2 rise ignored", {3'b0, req_o}, 4'h0);
        check("R2 no pulse", {3'b0, tmr_start_o}, 4'h0);
        move_pin(1'b0);
        check("R2 fall ignored", {3'b0, req_o}, 4'h0);
    endtask

    task automatic t_falling();
        write_cfg(4'b1000);   // pin low: active already, old inactive -> pseudo set
        clear_req();
        move_pin(1'b1);
        check("R3 rise ignored", {3'b0, req_o}, 4'h0);
        pin_i = 1'b0;
        cyc(2);
        check("R3 not yet", {3'b0, req_o}, 4'h0);
        cyc(1);
        check("R3 fall sets", {3'b0, req_o}, 4'h1);
        clear_req();
    endtask

    task automatic t_rising();
        write_cfg(4'b1100);   // pin low, active high -> inactive both sides? old act 1, new 0
        clear_req();
        move_pin(1'b1);
        check("R4 rise sets", {3'b0, req_o}, 4'h1);
        clear_req();
        move_pin(1'b0);
        check("R4 fall ignored", {3'b0, req_o}, 4'h0);
    endtask

    task automatic t_both();
        write_cfg(4'b1110);
        clear_req();
        move_pin(1'b1);
        check("R5 rise sets", {3'b0, req_o}, 4'h1);
        clear_req();
        move_pin(1'b0);
        check("R5 fall sets", {3'b0, req_o}, 4'h1);
        clear_req();
    endtask

    task automatic t_level();
        write_cfg(4'b0100);  // active high, pin low
        check("R6 low vs high", {3'b0, lvl_match_o}, 4'h0);
        pin_i = 1'b1;
        cyc(2);
        check("R6 high vs high", {3'b0, lvl_match_o}, 4'h1);
        write_cfg(4'b0000);
        check("R6 high vs low", {3'b0, lvl_match_o}, 4'h0);
        pin_i = 1'b0;
        cyc(2);
        check("R6 low vs low", {3'b0, lvl_match_o}, 4'h1);
        clear_req();
    endtask

    task automatic t_pseudo();
        pin_i = 1'b1;
        cyc(4);
        write_cfg(4'b0000);
        clear_req();
        write_cfg(4'b1000);   // active low, pin high: 0 -> 0
        check("R7 no change", {3'b0, req_o}, 4'h0);
        write_cfg(4'b1100);   // now active: 0 -> 1
        check("R7 pol flip sets", {3'b0, req_o}, 4'h1);
        check("R9 no pulse pseudo", {3'b0, tmr_start_o}, 4'h0);
        clear_req();
        write_cfg(4'b1111);   // bits 3,2 unchanged
        check("R7 other bits", {3'b0, req_o}, 4'h0);
        write_cfg(4'b0111);   // disable: 1 -> 0
        check("R7 disable sets", {3'b0, req_o}, 4'h1);
        clear_req();
    endtask

    task automatic t_race();
        // req is 0, pin high, cfg 0111
        write_cfg(4'b1100);   // sets req
        check("R8 held", {3'b0, req_o}, 4'h1);
        cyc(3);
        check("R8 still held", {3'b0, req_o}, 4'h1);
        req_clr_i = 1'b1;
        cfg_wr_i = 1'b1; cfg_wdata_i = 4'b0100;  // 1 -> 0: set with clear
        cyc(1);
        cfg_wr_i = 1'b0; req_clr_i = 1'b0;
        check("R8 set wins", {3'b0, req_o}, 4'h1);
        clear_req();
        check("R8 clear drops", {3'b0, req_o}, 4'h0);
    endtask

    task automatic t_timer();
        write_cfg(4'b1101);   // pin high, active high: pseudo set
        clear_req();
        move_pin(1'b0);
        check("R9 wrong edge", {3'b0, tmr_start_o}, 4'h0);
        move_pin(1'b1);
        check("R9 pulse", {3'b0, tmr_start_o}, 4'h1);
        check("R9 with req", {3'b0, req_o}, 4'h1);
        cyc(1);
        check("R9 one cycle", {3'b0, tmr_start_o}, 4'h0);
        clear_req();
        write_cfg(4'b1100);
        clear_req();
        move_pin(1'b0);
        move_pin(1'b1);
        check("R9 bit0 off", {3'b0, tmr_start_o}, 4'h0);
        check("R9 req anyway", {3'b0, req_o}, 4'h1);
        clear_req();
    endtask

    task automatic t_select();
        tmr_irq_i = 1'b1; ser_irq_i = 1'b0;
        cyc(1);
        check("R10 timer path", {3'b0, shared_irq_o}, 4'h1);
        sel_wr_i = 1'b1; sel_wdata_i = 1'b1;
        cyc(1);
        sel_wr_i = 1'b0;
        check("R11 sel readback", {3'b0, sel_o}, 4'h1);
        check("R10 serial blocked timer", {3'b0, shared_irq_o}, 4'h0);
        ser_irq_i = 1'b1; tmr_irq_i = 1'b0;
        cyc(1);
        check("R10 serial path", {3'b0, shared_irq_o}, 4'h1);
        write_cfg(4'b1010);
        check("R11 cfg readback", cfg_rdata_o, 4'b1010);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_disabled();
        t_falling();
        t_rising();
        t_both();
        t_level();
        t_pseudo();
        t_race();
        t_timer();
        t_select();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule